// File: doc/BRIEF.md
# Six-Stage Pipeline Hazard Controller

This block is the occupancy and sequencing control for an in-order pipeline of six stages: instruction fetch, decode, operand address calculation, operand fetch, execute and operand write. It carries no datapath. Each instruction is a small token with a valid bit, a 4-bit sequence tag and three flags: whether it reads memory in operand fetch, whether it writes in the final stage, and whether it is a conditional branch. Every cycle the block decides which tokens move forward, which one waits and which ones are discarded.

Instruction fetch and operand fetch share one single-port memory. When the operand-fetch stage holds a token that reads memory, that access wins. The fetch stage keeps its token, decode receives a bubble, and no new instruction is taken in. A conditional branch learns its outcome only in the last stage. If it is taken, the five younger stages are emptied, and on the following cycle the fetch side is told to restart from the new address.

A fetch unit presents an instruction with `fetch_avail_i` and its flags. The instruction is taken at a clock edge when neither `fetch_stall_o` nor `flush_o` is high in the cycle before that edge. Retired tags come out of the last stage in program order, one per cycle at most.

Top module: `pipe6_hazard_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, with no instruction taken yet, every stage valid bit is 0, and `fetch_stall_o`, `flush_o`, `redirect_o`, `retire_o` and `wo_write_o` are all 0.
- R2: Stage i sits at bit i of `stage_valid_o` and in bits [4i+3:4i] of `stage_tag_o`: 0 fetch, 1 decode, 2 address, 3 operand fetch, 4 execute, 5 operand write. An instruction taken at edge E is in stage 0 after E. With no hazard it moves down one stage per edge and reaches stage 5 after E+5. From an empty pipeline fed every cycle, the valid vector after E+j is 2^(j+1)-1 for j = 0..5.
- R3: `retire_o` is high, with `retire_tag_o` equal to the tag, in exactly the cycles in which stage 5 holds a token. Without hazards, n instructions fed back to back all retire within k+n-1 = n+5 clocks: 9 instructions in 14.
- R4: When stage 3 holds a token that reads memory and stage 0 holds a token, `fetch_stall_o` is 1. At the next edge the stage-0 token stays where it is, decode becomes empty, and no new instruction is taken.
- R5: `fo_mem_rd_o` is 1 exactly while stage 3 holds a token that reads memory. A token that does not read memory, or one whose fetch stage is empty, causes no stall.
- R6: `wo_write_o` is 1 exactly while stage 5 holds a token flagged as writing. Tokens not flagged pass through that stage without it.
- R7: When stage 5 holds a branch token and `br_taken_i` is 1, `flush_o` is 1 in that cycle. After the next edge all six stages are empty, and no instruction is taken at that edge.
- R8: `redirect_o` is 1 in the cycle right after each `flush_o` cycle.
- R9: `br_taken_i` has no effect unless stage 5 holds a branch token. A branch that is not taken flows through like any other instruction.
- R10: Tags start at 0 after reset and rise by 1, modulo 16, for each instruction taken. Retired tags therefore appear in program order, and the tags of flushed instructions are skipped.
- R11: An instruction is taken at an edge exactly when `fetch_avail_i` is 1 and both `fetch_stall_o` and `flush_o` are 0 in the cycle before that edge. Each stall cycle delays later retirements by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fetch_avail_i | input | 1 | An instruction is offered for fetch |
| fetch_uses_fo_i | input | 1 | Offered instruction reads memory in operand fetch |
| fetch_uses_wo_i | input | 1 | Offered instruction writes in the final stage |
| fetch_is_br_i | input | 1 | Offered instruction is a conditional branch |
| br_taken_i | input | 1 | Outcome of the branch now in the final stage |
| stage_valid_o | output | 6 | Valid bit of each stage, bit i = stage i |
| stage_tag_o | output | 24 | Tags of all stages, 4 bits per stage |
| fetch_stall_o | output | 1 | Fetch slot held for an operand memory access |
| flush_o | output | 1 | Taken branch: all younger stages are discarded |
| redirect_o | output | 1 | Fetch restarts at the branch target this cycle |
| fo_mem_rd_o | output | 1 | Operand fetch owns the memory port |
| wo_write_o | output | 1 | Final stage performs its write |
| retire_o | output | 1 | A token completes this cycle |
| retire_tag_o | output | 4 | Tag of the completing token |

## Verification
The memory-port conflict and the taken-branch flush can land in the same cycle. A taken branch in the last stage may coincide with a memory-reading token in operand fetch and a held token in fetch. The streams feed back-to-back instructions with memory-reading tokens placed one after another, so that two stall cycles in a row shift every later retirement by exactly two clocks. A separate stream places a taken branch behind a full pipeline. In that stream the bench checks that nothing younger than the branch retires, that the next instruction taken still carries the next tag in sequence, and that the redirect follows the flush by exactly one cycle.

// File: rtl/p6_pkg.sv
package p6_pkg;
  localparam int P6_STAGES = 6;

  // stage order is behaviour: index 0 is the youngest
  typedef enum logic [2:0] {
    ST_FI = 3'd0,
    ST_DI = 3'd1,
    ST_CO = 3'd2,
    ST_FO = 3'd3,
    ST_EI = 3'd4,
    ST_WO = 3'd5
  } p6_stage_e;

  localparam int IDX_FI = int'(ST_FI);
  localparam int IDX_FO = int'(ST_FO);
  localparam int IDX_WO = int'(ST_WO);
endpackage

// File: rtl/p6_stage_slot.sv
module p6_stage_slot #(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             load_i,
  input  logic             hold_i,
  input  logic             up_vld_i,
  input  logic [TAG_W-1:0] up_tag_i,
  input  logic             up_fo_i,
  input  logic             up_wo_i,
  input  logic             up_br_i,
  output logic             vld_o,
  output logic [TAG_W-1:0] tag_o,
  output logic             fo_o,
  output logic             wo_o,
  output logic             br_o
);
  logic             vld_q, vld_d;
  logic [TAG_W-1:0] tag_q;
  logic             fo_q, wo_q, br_q;
  logic             dat_en;

  always_comb begin
    dat_en = load_i & ~flush_i;
    if (flush_i)     vld_d = 1'b0;
    else if (load_i) vld_d = up_vld_i;
    else if (hold_i) vld_d = vld_q;
    else             vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      tag_q <= '0;
      fo_q  <= 1'b0;
      wo_q  <= 1'b0;
      br_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (dat_en) begin
        tag_q <= up_tag_i;
        fo_q  <= up_fo_i;
        wo_q  <= up_wo_i;
        br_q  <= up_br_i;
      end
    end
  end

  assign vld_o = vld_q;
  assign tag_o = tag_q;
  assign fo_o  = fo_q;
  assign wo_o  = wo_q;
  assign br_o  = br_q;
endmodule

// File: rtl/p6_hazard_arb.sv
module p6_hazard_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic fetch_avail_i,
  input  logic br_taken_i,
  input  logic fi_vld_i,
  input  logic fo_vld_i,
  input  logic fo_mem_i,
  input  logic wo_vld_i,
  input  logic wo_br_i,
  output logic fo_busy_o,
  output logic flush_o,
  output logic fetch_stall_o,
  output logic fi_go_o,
  output logic accept_o,
  output logic redirect_o
);
  logic port_taken;
  logic redir_q;

  always_comb begin
    port_taken    = fo_vld_i & fo_mem_i;
    flush_o       = wo_vld_i & wo_br_i & br_taken_i;
    fetch_stall_o = fi_vld_i & port_taken & ~flush_o;
    fi_go_o       = fi_vld_i & ~port_taken & ~flush_o;
    accept_o      = fetch_avail_i & ~flush_o & ~(fi_vld_i & port_taken);
    fo_busy_o     = port_taken;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) redir_q <= 1'b0;
    else        redir_q <= flush_o;
  end

  assign redirect_o = redir_q;
endmodule

// File: rtl/p6_tag_gen.sv
module p6_tag_gen #(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  output logic [TAG_W-1:0] tag_o
);
  logic [TAG_W-1:0] cnt_q, cnt_d;

  always_comb cnt_d = cnt_q + TAG_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_d;
  end

  assign tag_o = cnt_q;
endmodule

// File: rtl/pipe6_hazard_ctrl.sv
module pipe6_hazard_ctrl
  import p6_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fetch_avail_i,
  input  logic                         fetch_uses_fo_i,
  input  logic                         fetch_uses_wo_i,
  input  logic                         fetch_is_br_i,
  input  logic                         br_taken_i,
  output logic [P6_STAGES-1:0]         stage_valid_o,
  output logic [P6_STAGES*TAG_W-1:0]   stage_tag_o,
  output logic                         fetch_stall_o,
  output logic                         flush_o,
  output logic                         redirect_o,
  output logic                         fo_mem_rd_o,
  output logic                         wo_write_o,
  output logic                         retire_o,
  output logic [TAG_W-1:0]             retire_tag_o
);
  localparam int NS = P6_STAGES;

  logic [NS-1:0]    vld, fo, wo, br;
  logic [NS-1:0]    up_vld, up_fo, up_wo, up_br, ld, hd;
  logic [TAG_W-1:0] tag    [NS];
  logic [TAG_W-1:0] up_tag [NS];
  logic [TAG_W-1:0] nxt_tag;
  logic             fo_busy, fi_go, accept;

  p6_hazard_arb u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_avail_i(fetch_avail_i),
    .br_taken_i   (br_taken_i),
    .fi_vld_i     (vld[IDX_FI]),
    .fo_vld_i     (vld[IDX_FO]),
    .fo_mem_i     (fo[IDX_FO]),
    .wo_vld_i     (vld[IDX_WO]),
    .wo_br_i      (br[IDX_WO]),
    .fo_busy_o    (fo_busy),
    .flush_o      (flush_o),
    .fetch_stall_o(fetch_stall_o),
    .fi_go_o      (fi_go),
    .accept_o     (accept),
    .redirect_o   (redirect_o)
  );

  p6_tag_gen #(.TAG_W(TAG_W)) u_tag (
    .clk  (clk),
    .rst_n(rst_n),
    .adv_i(accept),
    .tag_o(nxt_tag)
  );

  // upstream selection: stage 0 takes the offered instruction,
  // stage 1 takes the fetch slot only when it has won the port,
  // later stages shift every cycle
  always_comb begin
    up_vld[0] = 1'b1;
    up_tag[0] = nxt_tag;
    up_fo[0]  = fetch_uses_fo_i;
    up_wo[0]  = fetch_uses_wo_i;
    up_br[0]  = fetch_is_br_i;
    ld[0]     = accept;
    hd[0]     = ~fi_go;
    for (int i = 1; i < NS; i++) begin
      up_vld[i] = vld[i-1];
      up_tag[i] = tag[i-1];
      up_fo[i]  = fo[i-1];
      up_wo[i]  = wo[i-1];
      up_br[i]  = br[i-1];
      ld[i]     = (i == 1) ? fi_go : 1'b1;
      hd[i]     = 1'b0;
    end
  end

  for (genvar g = 0; g < NS; g++) begin : g_stage
    p6_stage_slot #(.TAG_W(TAG_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (flush_o),
      .load_i  (ld[g]),
      .hold_i  (hd[g]),
      .up_vld_i(up_vld[g]),
      .up_tag_i(up_tag[g]),
      .up_fo_i (up_fo[g]),
      .up_wo_i (up_wo[g]),
      .up_br_i (up_br[g]),
      .vld_o   (vld[g]),
      .tag_o   (tag[g]),
      .fo_o    (fo[g]),
      .wo_o    (wo[g]),
      .br_o    (br[g])
    );
    assign stage_tag_o[g*TAG_W +: TAG_W] = tag[g];
  end

  assign stage_valid_o = vld;
  assign fo_mem_rd_o   = fo_busy;
  assign wo_write_o    = vld[IDX_WO] & wo[IDX_WO];
  assign retire_o      = vld[IDX_WO];
  assign retire_tag_o  = tag[IDX_WO];
endmodule

// File: rtl/p6_hazard_chk.sv
module p6_hazard_chk
  import p6_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [P6_STAGES-1:0]       stage_valid_o,
  input logic [P6_STAGES*TAG_W-1:0] stage_tag_o,
  input logic                       fetch_stall_o,
  input logic                       flush_o,
  input logic                       redirect_o,
  input logic                       fo_mem_rd_o
);
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> (stage_valid_o == '0)); // R7

  AST_REDIRECT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> redirect_o); // R8

  AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall_o |=> !stage_valid_o[1]); // R4

  AST_STALL_HOLDS_FI: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall_o |=> (stage_valid_o[0] &&
      stage_tag_o[TAG_W-1:0] == $past(stage_tag_o[TAG_W-1:0]))); // R4

  AST_STALL_NEEDS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall_o |-> fo_mem_rd_o); // R5

  AST_SHIFT_TO_WO: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_valid_o[4] && !flush_o) |=> (stage_valid_o[5] &&
      stage_tag_o[5*TAG_W +: TAG_W] == $past(stage_tag_o[4*TAG_W +: TAG_W]))); // R2
endmodule

bind pipe6_hazard_ctrl p6_hazard_chk #(.TAG_W(TAG_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stage_valid_o(stage_valid_o),
  .stage_tag_o  (stage_tag_o),
  .fetch_stall_o(fetch_stall_o),
  .flush_o      (flush_o),
  .redirect_o   (redirect_o),
  .fo_mem_rd_o  (fo_mem_rd_o)
);

// File: tb/pipe6_hazard_ctrl_test.sv
module pipe6_hazard_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_avail_i = 1'b0, fetch_uses_fo_i = 1'b0;
  logic        fetch_uses_wo_i = 1'b0, fetch_is_br_i = 1'b0, br_taken_i = 1'b0;
  logic [5:0]  stage_valid_o;
  logic [23:0] stage_tag_o;
  logic        fetch_stall_o, flush_o, redirect_o, fo_mem_rd_o, wo_write_o, retire_o;
  logic [3:0]  retire_tag_o;

  pipe6_hazard_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .fetch_avail_i(fetch_avail_i), .fetch_uses_fo_i(fetch_uses_fo_i),
    .fetch_uses_wo_i(fetch_uses_wo_i), .fetch_is_br_i(fetch_is_br_i),
    .br_taken_i(br_taken_i),
    .stage_valid_o(stage_valid_o), .stage_tag_o(stage_tag_o),
    .fetch_stall_o(fetch_stall_o), .flush_o(flush_o), .redirect_o(redirect_o),
    .fo_mem_rd_o(fo_mem_rd_o), .wo_write_o(wo_write_o),
    .retire_o(retire_o), .retire_tag_o(retire_tag_o)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // activity log, filled shortly after each falling edge
  int ret_n, flush_n, redir_n, stall_n, fo_n, wo_n;
  int flush_cyc, redir_cyc, stall_cyc0;
  int ret_tag [64];
  int ret_cyc [64];
  logic [5:0] sv_log [64];

  always @(negedge clk) begin
    #2;
    sv_log[cyc & 63] = stage_valid_o;
    if (rst_n) begin
      if (retire_o && ret_n < 64) begin
        ret_tag[ret_n] = int'(retire_tag_o);
        ret_cyc[ret_n] = cyc;
        ret_n++;
      end
      if (flush_o)       begin flush_n++; flush_cyc = cyc; end
      if (redirect_o)    begin redir_n++; redir_cyc = cyc; end
      if (fetch_stall_o) begin if (stall_n == 0) stall_cyc0 = cyc; stall_n++; end
      if (fo_mem_rd_o)   fo_n++;
      if (wo_write_o)    wo_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    ret_n = 0; flush_n = 0; redir_n = 0; stall_n = 0; fo_n = 0; wo_n = 0;
    flush_cyc = -1; redir_cyc = -1; stall_cyc0 = -1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    fetch_avail_i = 0; fetch_uses_fo_i = 0; fetch_uses_wo_i = 0;
    fetch_is_br_i = 0; br_taken_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    clear_log();
  endtask

  // offer n instructions; count only those taken (R11 rule)
  task automatic feed(input int n, input logic [31:0] fo_m, input logic [31:0] wo_m,
                      input logic [31:0] br_m, output int start);
    int idx = 0;
    bit first = 1;
    bit acc;
    start = 0;
    while (idx < n) begin
      @(negedge clk);
      fetch_avail_i   = 1'b1;
      fetch_uses_fo_i = fo_m[idx];
      fetch_uses_wo_i = wo_m[idx];
      fetch_is_br_i   = br_m[idx];
      #1;
      acc = !fetch_stall_o && !flush_o;
      @(posedge clk);
      #1;
      if (acc) begin
        if (first) start = cyc;
        first = 0;
        idx++;
      end
    end
    @(negedge clk);
    fetch_avail_i = 0; fetch_uses_fo_i = 0; fetch_uses_wo_i = 0; fetch_is_br_i = 0;
  endtask

  task automatic drain();
    repeat (20) @(posedge clk);
    @(negedge clk);
    #3;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    chk(stage_valid_o == 0 && !fetch_stall_o && !flush_o && !redirect_o && !retire_o && !wo_write_o,
        "R1 in reset", int'(stage_valid_o), 0);
    do_reset();
    #2;
    chk(stage_valid_o == 0 && !fetch_stall_o && !flush_o && !redirect_o && !retire_o && !wo_write_o,
        "R1 after release", int'(stage_valid_o), 0);
  endtask

  task automatic t_fill();
    int s;
    do_reset();
    br_taken_i = 1'b1; // R9: no branch token, so no effect
    feed(9, 32'h0, 32'h24, 32'h0, s);
    drain();
    for (int j = 0; j < 6; j++)
      chk(sv_log[(s + j) & 63] == 6'((1 << (j + 1)) - 1), "R2 fill",
          int'(sv_log[(s + j) & 63]), (1 << (j + 1)) - 1);
    chk(ret_n == 9, "R3 retire count", ret_n, 9);
    chk(ret_cyc[0] - s == 5, "R2 first retire", ret_cyc[0] - s, 5);
    chk(ret_cyc[8] - s == 13, "R3 nine in fourteen", ret_cyc[8] - s, 13);
    for (int i = 0; i < 9; i++)
      chk(ret_tag[i] == i, "R10 tag order", ret_tag[i], i);
    chk(flush_n == 0, "R9 taken input ignored", flush_n, 0);
    chk(stall_n == 0 && fo_n == 0, "R5 no port use", stall_n, 0);
    chk(wo_n == 2, "R6 write count", wo_n, 2);
    br_taken_i = 1'b0;
  endtask

  task automatic t_conflict();
    int s;
    do_reset();
    feed(9, 32'h3, 32'h0, 32'h0, s);
    drain();
    chk(stall_n == 2, "R4 stall cycles", stall_n, 2);
    chk(stall_cyc0 - s == 3, "R4 stall timing", stall_cyc0 - s, 3);
    chk(sv_log[(s + 4) & 63] == 6'b011101, "R4 first bubble", int'(sv_log[(s + 4) & 63]), 29);
    chk(sv_log[(s + 5) & 63] == 6'b111001, "R4 second bubble", int'(sv_log[(s + 5) & 63]), 57);
    chk(fo_n == 2, "R5 port owner cycles", fo_n, 2);
    chk(ret_n == 9, "R11 count", ret_n, 9);
    chk(ret_cyc[8] - s == 15, "R11 two-cycle delay", ret_cyc[8] - s, 15);
    for (int i = 0; i < 9; i++)
      chk(ret_tag[i] == i, "R10 order under stall", ret_tag[i], i);
  endtask

  task automatic t_lone();
    int s;
    do_reset();
    feed(1, 32'h1, 32'h0, 32'h0, s);
    drain();
    chk(stall_n == 0, "R5 empty fetch no stall", stall_n, 0);
    chk(fo_n == 1, "R5 port owner", fo_n, 1);
    chk(ret_n == 1 && ret_cyc[0] - s == 5, "R5 lone timing", ret_cyc[0] - s, 5);
  endtask

  task automatic t_branch();
    int s;
    do_reset();
    br_taken_i = 1'b1;
    feed(9, 32'h0, 32'h0, 32'h4, s);
    drain();
    chk(flush_n == 1, "R7 flush count", flush_n, 1);
    chk(flush_cyc - s == 7, "R7 flush timing", flush_cyc - s, 7);
    chk(sv_log[(s + 8) & 63] == 6'b0, "R7 emptied", int'(sv_log[(s + 8) & 63]), 0);
    chk(redir_n == 1 && redir_cyc - s == 8, "R8 redirect", redir_cyc - s, 8);
    chk(ret_n == 4, "R7 survivors", ret_n, 4);
    chk(ret_tag[0] == 0 && ret_tag[1] == 1 && ret_tag[2] == 2, "R10 pre-branch tags", ret_tag[2], 2);
    chk(ret_tag[3] == 8, "R10 skip flushed tags", ret_tag[3], 8);
    chk(ret_cyc[3] - s == 14, "R7 refetch timing", ret_cyc[3] - s, 14);
    br_taken_i = 1'b0;
  endtask

  task automatic t_not_taken();
    int s;
    do_reset();
    br_taken_i = 1'b0;
    feed(9, 32'h0, 32'h0, 32'h4, s);
    drain();
    chk(flush_n == 0 && redir_n == 0, "R9 not taken", flush_n, 0);
    chk(ret_n == 9 && ret_cyc[8] - s == 13, "R9 flows through", ret_cyc[8] - s, 13);
  endtask

  task automatic t_wrap();
    int s;
    do_reset();
    feed(20, 32'h11111, 32'h0, 32'h0, s);
    drain();
    chk(ret_n == 20, "R10 wrap count", ret_n, 20);
    for (int i = 0; i < 20; i++)
      chk(ret_tag[i] == (i % 16), "R10 wrap order", ret_tag[i], i % 16);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    clear_log();
    t_reset();
    t_fill();
    t_conflict();
    t_lone();
    t_branch();
    t_not_taken();
    t_wrap();
    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end
endmodule